// File: doc/BRIEF.md
# Frame-Aligned Two-Frame Slip Buffer

This block carries a framed T1 or E1 bit stream from a line-side write timing to a bus-side read timing. It stores two frames of payload. Both sides run on one clock and advance on per-bit enable strobes. Each side marks the first bit of every frame with a strobe. The write side fills the two frame halves in turn. The read side normally drains the half the writer filled one frame earlier.

When the two timings drift apart, the buffer corrects with a controlled slip. This happens only at a read frame boundary. The block measures how many bits the writer holds ahead of the frame the reader is about to start. If that margin has fallen below a guard, the reader plays the previous frame again. If the writer is about to catch the reader from behind, the reader skips one frame. Either way the read frame alignment stays intact.

Three status outputs report what happened:
- a sticky slip flag, which a processor clears by pulsing a status-read strobe;
- a direction bit for the most recent slip;
- a coarse delay flag.

A bypass input passes the write bit straight to the output.

Top module: `frame_slip_buffer`

## Requirements
- R1: `e1_mode` selects the frame length: 0 gives 193 bits and 1 gives 256 bits. The store holds two frames. Each write frame strobe starts writing at the base of the other half (offset 0 or one frame length). The first write frame after reset goes to offset 0.
- R2: Without a slip, read frame k outputs the bits of write frame k in order. The first read frame after reset plays the first write frame. Each bit appears on `rd_bit` in the cycle after its `rd_en`.
- R3: At a read frame boundary, the gap is the number of bits written ahead of the next nominal frame start. It counts writes of earlier cycles only. If the gap is below GUARD (12), the previous frame is played again in full and the direction becomes 1.
- R4: If that gap exceeds twice the frame length minus GUARD, one whole frame is skipped and the direction becomes 0.
- R5: Slip decisions are taken only in a cycle with both `rd_en` and `rd_frame`. Bit i of every read frame comes from bit i of its source frame.
- R6: `slip_evt` rises in the cycle after a slip and stays high until a status read.
- R7: A `stat_rd` pulse clears `slip_evt` in the next cycle. If a slip falls in the same cycle as the read, the flag stays high.
- R8: `slip_dir` changes only when a slip is taken. A status read does not alter it.
- R9: At every read frame boundary, `delay_flag` is reloaded. It becomes 1 if the gap measured after the slip decision exceeds the payload length (192 bits T1, 256 bits E1), otherwise 0. It holds between boundaries.
- R10: While `bypass` is 1, `rd_bit` equals `wr_bit` in the same cycle, no slip is taken, and `slip_evt` reads 0. The latched flag value returns when bypass ends.
- R11: Synchronous reset clears `slip_evt`, `slip_dir`, `delay_flag` and `rd_bit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for both sides |
| rst | input | 1 | Synchronous active-high reset |
| e1_mode | input | 1 | 0 = 193-bit frames, 1 = 256-bit frames |
| bypass | input | 1 | Route the write bit straight to the output |
| wr_en | input | 1 | Write bit enable |
| wr_frame | input | 1 | First bit of a write frame (with `wr_en`) |
| wr_bit | input | 1 | Write data bit |
| rd_en | input | 1 | Read bit enable |
| rd_frame | input | 1 | First bit of a read frame (with `rd_en`) |
| stat_rd | input | 1 | Status read strobe, clears the slip flag |
| rd_bit | output | 1 | Read data bit |
| slip_evt | output | 1 | Sticky controlled-slip flag |
| slip_dir | output | 1 | Last slip: 1 = frame repeated, 0 = frame dropped |
| delay_flag | output | 1 | Gap above one frame of payload |

## Verification
A slip being latched and a processor status read that clears the flag can land on the same clock edge. The bench predicts every slip from its own count of written bits and read frame starts. It raises `stat_rd` exactly in the first predicted slip cycle of each run. On the next cycle it demands that `slip_evt` be high. The same flag model also judges the isolated periodic reads, which must clear the flag.

// File: rtl/fsb_pkg.sv
package fsb_pkg;

    parameter int unsigned POS_W = 10;

    typedef logic [POS_W-1:0] pos_t;

    localparam pos_t ONE = pos_t'(1);

    typedef enum logic [1:0] {
        SLIP_NONE   = 2'd0,
        SLIP_REPEAT = 2'd1,
        SLIP_DELETE = 2'd2
    } slip_kind_e;

    // Outcome of a read frame boundary
    typedef struct packed {
        logic       strobe;
        slip_kind_e kind;
        pos_t       gap_after;
    } frame_evt_t;

    // Distance from base forward to lead on a ring of two frames
    function automatic pos_t ring_gap(pos_t lead, pos_t base, pos_t len);
        if (lead >= base) return lead - base;
        return lead + (len << 1) - base;
    endfunction

    function automatic pos_t half_base(logic half, pos_t len);
        return half ? len : '0;
    endfunction

endpackage

// File: rtl/fsb_wr_side.sv
module fsb_wr_side
    import fsb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic wr_frame,
    input  pos_t len,
    output pos_t waddr,
    output pos_t wpos
);

    logic half_q;
    pos_t cnt_q;

    always_comb begin
        if (wr_frame)
            waddr = half_base(~half_q, len);
        else
            waddr = half_base(half_q, len) + ((cnt_q == len) ? len - ONE : cnt_q);
        if (half_q)
            wpos = (cnt_q == len) ? '0 : len + cnt_q;
        else
            wpos = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            half_q <= 1'b1;
            cnt_q  <= len;
        end else if (wr_en) begin
            if (wr_frame) begin
                half_q <= ~half_q;
                cnt_q  <= ONE;
            end else if (cnt_q != len) begin
                cnt_q <= cnt_q + ONE;
            end
        end
    end

endmodule

// File: rtl/fsb_rd_side.sv
module fsb_rd_side
    import fsb_pkg::*;
#(
    parameter int unsigned GUARD = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rd_en,
    input  logic       rd_frame,
    input  logic       bypass,
    input  pos_t       len,
    input  pos_t       wpos,
    output pos_t       raddr,
    output frame_evt_t ev
);

    localparam pos_t GUARD_P = pos_t'(GUARD);

    logic       half_q;
    pos_t       cnt_q;
    logic       nom_half;
    logic       next_half;
    pos_t       gap_nom;
    slip_kind_e kind;

    always_comb begin
        nom_half = ~half_q;
        gap_nom  = ring_gap(wpos, half_base(nom_half, len), len);
        kind     = SLIP_NONE;
        if (!bypass) begin
            if (gap_nom < GUARD_P)
                kind = SLIP_REPEAT;
            else if (gap_nom > (len << 1) - GUARD_P)
                kind = SLIP_DELETE;
        end
        // either slip lands on the half just played
        next_half    = (kind == SLIP_NONE) ? nom_half : half_q;
        ev.strobe    = rd_en && rd_frame;
        ev.kind      = ev.strobe ? kind : SLIP_NONE;
        ev.gap_after = ring_gap(wpos, half_base(next_half, len), len);
        raddr        = ev.strobe ? half_base(next_half, len)
                                 : half_base(half_q, len) + cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            half_q <= 1'b1;
            cnt_q  <= '0;
        end else if (rd_en) begin
            if (rd_frame) begin
                half_q <= next_half;
                cnt_q  <= ONE;
            end else begin
                cnt_q <= (cnt_q == len - ONE) ? '0 : cnt_q + ONE;
            end
        end
    end

endmodule

// File: rtl/fsb_bitmem.sv
module fsb_bitmem
    import fsb_pkg::*;
#(
    parameter int unsigned DEPTH = 1 << POS_W
) (
    input  logic clk,
    input  logic rst,
    input  logic we,
    input  pos_t waddr,
    input  logic wbit,
    input  logic re,
    input  pos_t raddr,
    output logic rbit
);

    logic [DEPTH-1:0] store;

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wbit;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rbit <= 1'b0;
        else if (re)
            rbit <= store[raddr];
    end

endmodule

// File: rtl/fsb_status.sv
module fsb_status
    import fsb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  frame_evt_t ev,
    input  logic       stat_rd,
    input  pos_t       pay,
    output logic       evt_q,
    output logic       dir_q,
    output logic       dly_q
);

    logic slipped;

    assign slipped = ev.strobe && (ev.kind != SLIP_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_q <= 1'b0;
            dir_q <= 1'b0;
            dly_q <= 1'b0;
        end else begin
            // a slip wins over a clearing read in the same cycle
            if (slipped) begin
                evt_q <= 1'b1;
                dir_q <= (ev.kind == SLIP_REPEAT);
            end else if (stat_rd) begin
                evt_q <= 1'b0;
            end
            if (ev.strobe) dly_q <= (ev.gap_after > pay);
        end
    end

endmodule

// File: rtl/frame_slip_buffer.sv
module frame_slip_buffer
    import fsb_pkg::*;
#(
    parameter int unsigned T1_LEN = 193,
    parameter int unsigned E1_LEN = 256,
    parameter int unsigned T1_PAY = 192,
    parameter int unsigned E1_PAY = 256,
    parameter int unsigned GUARD  = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic e1_mode,
    input  logic bypass,
    input  logic wr_en,
    input  logic wr_frame,
    input  logic wr_bit,
    input  logic rd_en,
    input  logic rd_frame,
    input  logic stat_rd,
    output logic rd_bit,
    output logic slip_evt,
    output logic slip_dir,
    output logic delay_flag
);

    localparam int unsigned MEM_DEPTH = 1 << POS_W;

    pos_t       len;
    pos_t       pay;
    pos_t       waddr;
    pos_t       wpos;
    pos_t       raddr;
    frame_evt_t frame_ev;
    logic       mem_bit;
    logic       evt_q;

    assign len = e1_mode ? pos_t'(E1_LEN) : pos_t'(T1_LEN);
    assign pay = e1_mode ? pos_t'(E1_PAY) : pos_t'(T1_PAY);

    fsb_wr_side u_wr (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_frame (wr_frame),
        .len      (len),
        .waddr    (waddr),
        .wpos     (wpos)
    );

    fsb_rd_side #(.GUARD(GUARD)) u_rd (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .rd_frame (rd_frame),
        .bypass   (bypass),
        .len      (len),
        .wpos     (wpos),
        .raddr    (raddr),
        .ev       (frame_ev)
    );

    fsb_bitmem #(.DEPTH(MEM_DEPTH)) u_mem (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en),
        .waddr (waddr),
        .wbit  (wr_bit),
        .re    (rd_en),
        .raddr (raddr),
        .rbit  (mem_bit)
    );

    fsb_status u_stat (
        .clk     (clk),
        .rst     (rst),
        .ev      (frame_ev),
        .stat_rd (stat_rd),
        .pay     (pay),
        .evt_q   (evt_q),
        .dir_q   (slip_dir),
        .dly_q   (delay_flag)
    );

    assign rd_bit   = bypass ? wr_bit : mem_bit;
    assign slip_evt = evt_q & ~bypass;

endmodule

// File: rtl/fsb_checker.sv
module fsb_checker
    import fsb_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       bypass,
    input logic       rd_en,
    input logic       rd_frame,
    input logic       stat_rd,
    input logic       wr_en,
    input frame_evt_t frame_ev,
    input logic       evt_q,
    input logic       dir_q,
    input pos_t       waddr,
    input pos_t       len
);

    logic slip;

    assign slip = frame_ev.strobe && (frame_ev.kind != SLIP_NONE);

    // R6
    slip_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        slip |=> evt_q);

    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        evt_q && !stat_rd |=> evt_q);

    // R7
    read_clears_flag_chk: assert property (@(posedge clk) disable iff (rst)
        stat_rd && !slip |=> !evt_q);

    // R8
    dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !slip |=> $stable(dir_q));

    // R5
    boundary_only_chk: assert property (@(posedge clk) disable iff (rst)
        slip |-> (rd_en && rd_frame));

    // R10
    bypass_no_slip_chk: assert property (@(posedge clk) disable iff (rst)
        bypass |-> !slip);

    // R1
    wr_addr_range_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (waddr < (len << 1)));

endmodule

bind frame_slip_buffer fsb_checker chk_i (
    .clk      (clk),
    .rst      (rst),
    .bypass   (bypass),
    .rd_en    (rd_en),
    .rd_frame (rd_frame),
    .stat_rd  (stat_rd),
    .wr_en    (wr_en),
    .frame_ev (frame_ev),
    .evt_q    (evt_q),
    .dir_q    (slip_dir),
    .waddr    (waddr),
    .len      (len)
);

// File: tb/frame_slip_buffer_tb_top.sv
module frame_slip_buffer_tb_top;

    localparam int GUARD = 12;
    localparam int W_UNITS = 400;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic e1_mode = 1'b0;
    logic bypass = 1'b0;
    logic wr_en = 1'b0;
    logic wr_frame = 1'b0;
    logic wr_bit = 1'b0;
    logic rd_en = 1'b0;
    logic rd_frame = 1'b0;
    logic stat_rd = 1'b0;
    logic rd_bit, slip_evt, slip_dir, delay_flag;

    always #4 clk = ~clk;

    frame_slip_buffer dut_i (
        .clk(clk), .rst(rst), .e1_mode(e1_mode), .bypass(bypass),
        .wr_en(wr_en), .wr_frame(wr_frame), .wr_bit(wr_bit),
        .rd_en(rd_en), .rd_frame(rd_frame), .stat_rd(stat_rd),
        .rd_bit(rd_bit), .slip_evt(slip_evt), .slip_dir(slip_dir),
        .delay_flag(delay_flag)
    );

    int n_chk = 0;
    int n_fail = 0;
    int fl, thr, rd_units;
    int wacc, racc, wix, wfr, rix, src, wtot, cyc;
    int n_rep, n_del;
    bit started, rd_pend, coin_want, coin_pend, periodic;
    bit exp_evt, exp_dir, exp_dly;
    bit exp_q[$];
    string tag_q[$];
    string frame_tag;

    function automatic bit dbit(int f, int i);
        return bit'((f + i * 13 + (i >> 2)) & 1);
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic begin_run(bit e1);
        e1_mode = e1;
        fl  = e1 ? 256 : 193;
        thr = e1 ? 256 : 192;
        rst = 1'b1;
        wr_en = 0; wr_frame = 0; rd_en = 0; rd_frame = 0; stat_rd = 0; bypass = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        chk("R11", "slip_evt after reset", slip_evt, 0);
        chk("R11", "slip_dir after reset", slip_dir, 0);
        chk("R11", "delay_flag after reset", delay_flag, 0);
        chk("R11", "rd_bit after reset", rd_bit, 0);
        wacc = W_UNITS - 100; racc = 0; wix = 0; wfr = 0; rix = 0; src = -1;
        wtot = 0; cyc = 0; started = 0; rd_pend = 0; coin_want = 1; coin_pend = 0;
        exp_evt = 0; exp_dir = 0; exp_dly = 0; n_rep = 0; n_del = 0;
        frame_tag = "R2";
        exp_q.delete(); tag_q.delete();
    endtask

    // monitor side of the scoreboard: compare results of the last edge
    task automatic check_outputs();
        if (rd_pend) begin
            bit e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, "read bit", rd_bit, e);
        end
        chk("R6/R7", "slip_evt", slip_evt, exp_evt);
        chk("R8", "slip_dir", slip_dir, exp_dir);
        chk("R9", "delay_flag", delay_flag, exp_dly);
        if (coin_pend) chk("R7", "flag kept on coincident read", slip_evt, 1);
        coin_pend = 0;
    endtask

    // driver side: drive one cycle and push expected items
    task automatic drive_cycle();
        bit slip, rep;
        slip = 0; rep = 0;
        wr_en = 0; wr_frame = 0; rd_en = 0; rd_frame = 0; stat_rd = 0;
        wacc += 100;
        if (wacc >= W_UNITS) begin
            wacc -= W_UNITS;
            wr_en = 1; wr_frame = (wix == 0); wr_bit = dbit(wfr, wix);
        end
        if (!started && wtot >= fl) begin
            started = 1; racc = rd_units - 100;
        end
        if (started) begin
            racc += 100;
            if (racc >= rd_units) begin
                racc -= rd_units;
                rd_en = 1; rd_frame = (rix == 0);
                if (rix == 0) begin
                    int nom, gap;
                    nom = src + 1;
                    gap = wtot - nom * fl;
                    frame_tag = e1_mode ? "R1" : "R2";
                    if (gap < GUARD) begin
                        nom--; slip = 1; rep = 1; n_rep++; frame_tag = "R3";
                    end else if (gap > 2 * fl - GUARD) begin
                        nom++; slip = 1; rep = 0; n_del++; frame_tag = "R4";
                    end
                    src = nom;
                    exp_dly = (wtot - src * fl) > thr;
                end
                exp_q.push_back(dbit(src, rix));
                tag_q.push_back(rix == 0 ? "R5" : frame_tag);
                rix = (rix + 1) % fl;
            end
        end
        if (slip) begin
            exp_evt = 1; exp_dir = rep;
            if (coin_want) begin
                stat_rd = 1; coin_want = 0; coin_pend = 1;
            end
        end else if (periodic && (cyc % 500 == 250)) begin
            stat_rd = 1; exp_evt = 0;
        end
        rd_pend = rd_en;
        if (wr_en) begin
            wtot++;
            wix++;
            if (wix == fl) begin wix = 0; wfr++; end
        end
        cyc++;
    endtask

    task automatic run_cycles(int n);
        repeat (n) begin
            @(negedge clk);
            check_outputs();
            drive_cycle();
        end
    endtask

    initial begin
        // T1: read faster, then slower than write
        periodic = 1;
        begin_run(0);
        rd_units = 388;
        run_cycles(30000);
        chk("R3", "repeat slips while read fast", int'(n_rep >= 1), 1);
        chk("R4", "no delete while read fast", n_del, 0);
        rd_units = 412; n_del = 0;
        run_cycles(34000);
        chk("R4", "delete slips while read slow", int'(n_del >= 1), 1);

        // E1: read slower, flag left uncleared for bypass check
        periodic = 0;
        begin_run(1);
        rd_units = 412;
        run_cycles(40000);
        chk("R4", "E1 delete slips", int'(n_del >= 1), 1);
        chk("R3", "E1 no repeat while read slow", n_rep, 0);

        // bypass
        @(negedge clk);
        check_outputs();
        wr_en = 0; wr_frame = 0; rd_en = 0; rd_frame = 0; stat_rd = 0;
        bypass = 1;
        for (int k = 0; k < 8; k++) begin
            wr_bit = k[0] ^ k[2];
            wr_en = 1;
            #1;
            chk("R10", "rd_bit follows wr_bit", rd_bit, wr_bit);
            chk("R10", "slip_evt masked", slip_evt, 0);
            @(negedge clk);
        end
        wr_en = 0;
        bypass = 0;
        #1;
        chk("R10", "latched flag back after bypass", slip_evt, exp_evt);
        chk("R10", "latched flag was set", slip_evt, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule